// File: doc/BRIEF.md
# Virtual Address Range Selector

This block sits in front of a stage-1 table walker and classifies every incoming 64-bit virtual address. It reports whether the walk should start from the lower-range base register (base 0) or the upper-range base register (base 1). If the upper address bits it examines disagree, it reports a range fault instead. The walker receives the address back unchanged, together with the result.

Two controls set which upper bits are examined. A wide-space request switches the lowest examined bit from 48 to 52, but only when the 64KB granule is also reported. When top-byte-ignore is set, the highest examined bit drops from 63 to 55. An address that has every examined bit at zero selects base 0. One that has every examined bit at one selects base 1. Any other address is a fault.

Transfers use valid/ready on both sides. There is a single register stage, which accepts one address per cycle whenever the downstream side is not holding it back.

Top module: `va_range_sel`

## Requirements
- R1: In narrow mode with top-byte-ignore off, bits 63:48 are examined. All zero (0x0000000000000000 to 0x0000FFFFFFFFFFFF) gives outSelUpper=0. All one (0xFFFF000000000000 to 0xFFFFFFFFFFFFFFFF) gives outSelUpper=1. In both cases outFault=0.
- R2: When inWide=1 and inGran64k=1, bits 63:52 are examined. Addresses up to 0x000FFFFFFFFFFFFF select base 0, and addresses from 0xFFF0000000000000 upward select base 1.
- R3: A mixture of zeros and ones in the examined bits gives outFault=1, and outSelUpper is then forced to 0.
- R4: With inTagIgnore=1, the examined field is bits 55:48 in narrow mode and bits 55:52 in wide mode. Bits 63:56 then have no effect on outSelUpper or outFault.
- R5: With inWide=1 and inGran64k=0, the block examines bits 63:48 (or 55:48), exactly as in narrow mode.
- R6: An address accepted at a clock edge (inValid=1 and inReady=1) appears on outAddr with outValid=1 right after that same edge.
- R7: While outValid=1 and outReady=0, inReady=0 and outValid, outAddr, outSelUpper and outFault all hold their values.
- R8: While outReady=1, inReady=1, and a new address can be accepted on every cycle.
- R9: A synchronous active-high rst clears outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Address offered |
| inReady | output | 1 | Address will be taken at this edge |
| inAddr | input | 64 | Virtual address |
| inWide | input | 1 | Request 52-bit address space |
| inGran64k | input | 1 | 64KB granule in use |
| inTagIgnore | input | 1 | Exclude bits 63:56 from the check |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outAddr | output | 64 | Echoed address |
| outSelUpper | output | 1 | 1 selects base register 1 |
| outFault | output | 1 | Examined bits are not uniform |

## Verification
The bench probes the edges of each range. It uses addresses one past the top of the lower range, and addresses just below the bottom of the upper range. A wrong lowest examined bit would therefore make such an address select a base instead of faulting, or the reverse. A wide request is also sent without the 64KB granule. A design that ignores the granule would accept 0x000FFFFFFFFFFFFF, when it should fault. With top-byte-ignore set, the tag byte is filled with junk. A design that still examines that byte faults on addresses that should pass. Finally, the output is stalled while the next address waits on the input. A wrong ready equation would either lose the held result or swallow the waiting address.

// File: rtl/va_range_pkg.sv
package va_range_pkg;
  localparam int ADDR_W     = 64;
  localparam int LSB_NARROW = 48;
  localparam int LSB_WIDE   = 52;
  localparam int TAG_LSB    = 56;

  typedef struct packed {
    logic load;
  } strobes_t;

  typedef struct packed {
    logic selUpper;
    logic fault;
  } verdict_t;
endpackage

// File: rtl/va_range_classify.sv
module va_range_classify
  import va_range_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int LSB_N   = LSB_NARROW,
  parameter int LSB_W   = LSB_WIDE,
  parameter int TAG_LO  = TAG_LSB
) (
  input  logic [AW-1:0] addr,
  input  logic          wideEff,
  input  logic          tagIgnore,
  output verdict_t      verdict
);
  logic [AW-1:0] fieldMask;

  for (genvar i = 0; i < AW; i++) begin : g_mask
    localparam bit IN_NARROW = (i >= LSB_N);
    localparam bit IN_WIDE   = (i >= LSB_W);
    localparam bit BELOW_TAG = (i < TAG_LO);
    always_comb begin
      fieldMask[i] = (wideEff ? IN_WIDE : IN_NARROW) && (tagIgnore ? BELOW_TAG : 1'b1);
    end
  end

  logic allOnes;
  logic allZeros;

  always_comb begin
    allOnes          = &(addr | ~fieldMask);
    allZeros         = ~|(addr & fieldMask);
    verdict.fault    = ~(allOnes | allZeros);
    verdict.selUpper = allOnes & ~allZeros;
  end
endmodule

// File: rtl/va_range_dp.sv
module va_range_dp
  import va_range_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  strobes_t      strb,
  input  logic [AW-1:0] inAddr,
  input  logic          inWide,
  input  logic          inGran64k,
  input  logic          inTagIgnore,
  output logic [AW-1:0] outAddr,
  output logic          outSelUpper,
  output logic          outFault
);
  logic     wideEff;
  verdict_t verdictNext;
  logic [AW-1:0] addrQ;
  verdict_t      verdictQ;

  always_comb wideEff = inWide & inGran64k;

  va_range_classify #(.AW(AW)) u_classify (
    .addr     (inAddr),
    .wideEff  (wideEff),
    .tagIgnore(inTagIgnore),
    .verdict  (verdictNext)
  );

  always_ff @(posedge clk) begin
    if (strb.load) begin
      addrQ    <= inAddr;
      verdictQ <= verdictNext;
    end
  end

  always_comb begin
    outAddr     = addrQ;
    outFault    = verdictQ.fault;
    outSelUpper = verdictQ.selUpper & ~verdictQ.fault;
  end
endmodule

// File: rtl/va_range_ctrl.sv
module va_range_ctrl
  import va_range_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output strobes_t strb
);
  logic validQ;

  always_comb begin
    inReady   = ~validQ | outReady;
    strb.load = inValid & inReady;
    outValid  = validQ;
  end

  always_ff @(posedge clk) begin
    if (rst)            validQ <= 1'b0;
    else if (strb.load) validQ <= 1'b1;
    else if (outReady)  validQ <= 1'b0;
  end
endmodule

// File: rtl/va_range_sel.sv
module va_range_sel
  import va_range_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWide,
  input  logic              inGran64k,
  input  logic              inTagIgnore,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outSelUpper,
  output logic              outFault
);
  strobes_t strb;

  va_range_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strb    (strb)
  );

  va_range_dp #(.AW(ADDR_W)) u_dp (
    .clk        (clk),
    .strb       (strb),
    .inAddr     (inAddr),
    .inWide     (inWide),
    .inGran64k  (inGran64k),
    .inTagIgnore(inTagIgnore),
    .outAddr    (outAddr),
    .outSelUpper(outSelUpper),
    .outFault   (outFault)
  );
endmodule

// File: rtl/va_range_sel_chk.sv
module va_range_sel_chk
  import va_range_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outSelUpper,
  input logic              outFault
);
  // R1: the upper base is chosen only when bit 55 (always examined) is one
  p_upper_bit55_r1: assert property (@(posedge clk) disable iff (rst)
    outValid && outSelUpper |-> outAddr[55]);
  p_lower_bit55_r1: assert property (@(posedge clk) disable iff (rst)
    outValid && !outFault && !outSelUpper |-> !outAddr[55]);
  p_fault_no_sel_r3: assert property (@(posedge clk) disable iff (rst)
    outValid && outFault |-> !outSelUpper);
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid && outAddr == $past(inAddr));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outSelUpper) && $stable(outFault));
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);
  p_ready_r8: assert property (@(posedge clk) disable iff (rst)
    outReady |-> inReady);
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> !outValid);
endmodule

bind va_range_sel va_range_sel_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
  .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
  .outSelUpper(outSelUpper), .outFault(outFault)
);

// File: tb/va_range_sel_bench.sv
module va_range_sel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inAddr = '0;
  logic        inWide = 1'b0;
  logic        inGran64k = 1'b0;
  logic        inTagIgnore = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outAddr;
  logic        outSelUpper;
  logic        outFault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  va_range_sel u_va_range_sel (.*);

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      finishRun();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, check at following negedge
  task automatic classify(string req, logic [63:0] a, logic w, logic g, logic t,
                          logic expSel, logic expFault);
    @(negedge clk);
    inAddr = a; inWide = w; inGran64k = g; inTagIgnore = t;
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {63'd0, outValid}, 64'd1);
    check({req, " addr"}, outAddr, a);
    check({req, " sel"}, {63'd0, outSelUpper}, {63'd0, expSel});
    check({req, " fault"}, {63'd0, outFault}, {63'd0, expFault});
  endtask

  task automatic testReset();
    check("R9 reset", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    inAddr = 64'h1; inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears", {63'd0, outValid}, 64'd0);
    rst = 1'b0; outReady = 1'b1;
  endtask

  task automatic testNarrow();
    classify("R1 low", 64'h0000_1234_5678_9ABC, 0, 0, 0, 0, 0);
    classify("R1 low top", 64'h0000_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    classify("R1 high bottom", 64'hFFFF_0000_0000_0000, 0, 0, 0, 1, 0);
    classify("R1 high", 64'hFFFF_8000_0000_0000, 0, 0, 0, 1, 0);
  endtask

  task automatic testWide();
    classify("R2 low top", 64'h000F_FFFF_FFFF_FFFF, 1, 1, 0, 0, 0);
    classify("R2 high bottom", 64'hFFF0_0000_0000_0000, 1, 1, 0, 1, 0);
    classify("R2 past low", 64'h0010_0000_0000_0000, 1, 1, 0, 0, 1);
  endtask

  task automatic testFault();
    classify("R3 past low", 64'h0001_0000_0000_0000, 0, 0, 0, 0, 1);
    classify("R3 mixed", 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1);
    classify("R3 below high", 64'hFFFE_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1);
  endtask

  task automatic testTag();
    classify("R4 tag low", 64'hAB00_0000_1234_0000, 0, 0, 1, 0, 0);
    classify("R4 tag high", 64'h12FF_0000_0000_0000, 0, 0, 1, 1, 0);
    classify("R4 tag mixed", 64'h5A80_0000_0000_0000, 0, 0, 1, 0, 1);
    classify("R4 wide tag low", 64'h770F_0000_0000_0000, 1, 1, 1, 0, 0);
    classify("R4 wide tag high", 64'hA5F0_0000_0000_0000, 1, 1, 1, 1, 0);
  endtask

  task automatic testNoGranule();
    classify("R5 no granule low", 64'h000F_FFFF_FFFF_FFFF, 1, 0, 0, 0, 1);
    classify("R5 no granule high", 64'hFFF0_0000_0000_0000, 1, 0, 0, 0, 1);
    classify("R5 no granule ok", 64'hFFFF_0000_0000_0000, 1, 0, 0, 1, 0);
  endtask

  task automatic testStall();
    @(negedge clk);
    inAddr = 64'hFFFF_0000_0000_0001; inWide = 0; inGran64k = 0; inTagIgnore = 0;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    check("R6 accepted", {63'd0, outValid}, 64'd1);
    inAddr = 64'h0000_0000_0000_0002;
    check("R7 ready low", {63'd0, inReady}, 64'd0);
    @(negedge clk);
    check("R7 held addr", outAddr, 64'hFFFF_0000_0000_0001);
    check("R7 held sel", {63'd0, outSelUpper}, 64'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 next addr", outAddr, 64'h0000_0000_0000_0002);
    check("R7 next sel", {63'd0, outSelUpper}, 64'd0);
    @(negedge clk);
    check("R8 drained", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testStream();
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inWide = 0; inGran64k = 0; inTagIgnore = 0;
    for (int k = 0; k < 4; k++) begin
      inAddr = 64'h100 + 64'(k);
      @(negedge clk);
      check("R8 ready", {63'd0, inReady}, 64'd1);
      check("R8 stream addr", outAddr, 64'h100 + 64'(k));
      check("R8 stream valid", {63'd0, outValid}, 64'd1);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testNarrow();
    testWide();
    testFault();
    testTag();
    testNoGranule();
    testStall();
    testStream();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule